// File: doc/BRIEF.md
# Bit-Oriented Frame Transmitter with Per-Character Length

This block turns a sequence of characters into a bit-synchronous serial stream framed by flag octets. Between frames it sends the flag pattern continuously. When a character is waiting in its one-entry holding register and the current flag has finished, it starts a frame. Each character goes out least-significant bit first, with a length of 5 to 8 bits. A zero is inserted after every run of five ones inside the frame. When the holding register runs dry at a character boundary, the block appends a 16-bit check sequence and then goes back to flags.

The character length is read only when a character moves from the holding register into the shifter. Software can therefore change it between characters and build a data field of any bit count. Each change applies to the next character and never to the one being shifted. An optional clear-to-send gate holds back the start of a frame. Three latched status events mark the start of the check sequence, the return to flags and any change of the clear-to-send line. They can drive an interrupt output or be polled.

The data input is a plain write strobe with no back-pressure. `buf_empty` high means a write is accepted. A write made while `buf_empty` is low is dropped and raises `overrun`, so the writer must wait for `buf_empty` before each character. `bit_en` paces the output, one line bit per clock in which it is high.

Top module: `ftx_sdlc_tx`

## Requirements
- R1: After reset the holding register is empty (`buf_empty`=1), `overrun`, `ev_crc`, `ev_flag`, `ev_cts` and `stat_irq` are 0, and the line carries back-to-back flag octets 0x7E (bit order 0,1,1,1,1,1,1,0).
- R2: A character of N = `char_len`+5 bits (`char_len` 0..3 gives 5..8) is sent as bits 0..N-1 of the written byte, bit 0 first; bits N..7 are never sent.
- R3: `char_len` is sampled when a character enters the shifter; a change while a character is shifting leaves that character's length unchanged and applies to the next load.
- R4: Inside a frame, after five consecutive 1 bits of data or check sequence a 0 is inserted, and it does not count toward the character length; flag octets are never stuffed, so the line never shows seven ones in a row.
- R5: When the holding register is empty at the end of a character, the block sends the complement of the CRC-16 (polynomial x^16+x^12+x^5+1, bit-reflected, preset to all ones) over the frame's data bits, low-order bit first, followed by a closing flag.
- R6: With `auto_en`=1 a frame does not start while `cts` is 0, and the character stays in the holding register; with `auto_en`=0 `cts` is ignored.
- R7: `ev_crc` is set when the check sequence starts, `ev_flag` when flags resume after it, and `ev_cts` on any change of `cts`; each stays set until a `stat_ack` pulse clears it.
- R8: `stat_irq` is high exactly when `stat_ie`=1 and at least one event is set; with `stat_ie`=0 the events still latch for polling.
- R9: `buf_empty` rises when a character enters the shifter and falls on an accepted write; a write while `buf_empty`=0 is ignored, leaves the held character intact, and sets `overrun` until `stat_ack`.
- R10: A `chan_reset` pulse empties the holding register, clears `overrun` and all events, sets `txd` to 1 and restarts a flag octet.
- R11: While `bit_en` is 0, `txd` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_reset | input | 1 | Synchronous channel reset command |
| bit_en | input | 1 | Emit one line bit this cycle |
| char_len | input | 2 | Bits per character minus 5 |
| auto_en | input | 1 | Gate frame start on `cts` |
| cts | input | 1 | Clear-to-send, active high, already synchronized |
| stat_ie | input | 1 | Status interrupt enable |
| stat_ack | input | 1 | Clear latched events and overrun |
| buf_wr | input | 1 | Write strobe for the holding register |
| buf_data | input | 8 | Character, right-justified |
| buf_empty | output | 1 | Holding register can take a write |
| overrun | output | 1 | A write was dropped |
| txd | output | 1 | Serial line output |
| ev_crc | output | 1 | Check sequence has started |
| ev_flag | output | 1 | Flags have resumed after a frame |
| ev_cts | output | 1 | `cts` changed |
| stat_irq | output | 1 | Status interrupt |

## Verification
Every control result is registered: `buf_empty`, `overrun`, the three events and `stat_irq` change at the first rising edge after the write, acknowledge, reset command or `cts` change, and `txd` carries the bit chosen at the rising edge where `bit_en` was high. The bench drives inputs on the falling edge and reads these outputs on the next falling edge, half a cycle after they settle. Frame content is not timed bit by bit. The bench records `txd` after every enabled edge, removes stuffed zeros and splits the stream at flags. It then compares the data, check sequence and stuffing count with values it computes itself. A frame starts at most one flag octet after its first write, so each capture opens 40 cycles before the first character.

// File: rtl/ftx_pkg.sv
package ftx_pkg;
  typedef enum logic [1:0] {
    M_FLAG = 2'd0,
    M_DATA = 2'd1,
    M_FCS  = 2'd2
  } ftx_mode_e;

  localparam int EV_CRC = 0;
  localparam int EV_FLAG = 1;
  localparam int EV_CTS = 2;
  localparam int EV_N = 3;
endpackage

// File: rtl/ftx_crc.sv
module ftx_crc #(
  parameter int W = 16,
  parameter logic [W-1:0] POLY = 16'h8408
) (
  input  logic [W-1:0] crc_i,
  input  logic         bit_i,
  output logic [W-1:0] crc_o
);
  logic fb;
  assign fb    = crc_i[0] ^ bit_i;
  assign crc_o = (crc_i >> 1) ^ (fb ? POLY : '0);
endmodule

// File: rtl/ftx_txbuf.sv
module ftx_txbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] q,
  output logic              reject
);
  logic full_q;
  logic [DATA_W-1:0] data_q;

  assign reject = wr && full_q && !clr;
  assign full   = full_q;
  assign q      = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (clr) begin
      full_q <= 1'b0;
    end else if (take) begin
      full_q <= 1'b0;
    end else if (wr && !full_q) begin
      full_q <= 1'b1;
      data_q <= wdata;
    end
  end
endmodule

// File: rtl/ftx_status.sv
module ftx_status
  import ftx_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            ack,
  input  logic            ie,
  input  logic            cts,
  input  logic            crc_set,
  input  logic            flag_set,
  input  logic            ovr_set,
  output logic [EV_N-1:0] ev,
  output logic            overrun,
  output logic            irq
);
  logic cts_q, cts_vld;
  logic ovr_q;
  logic [EV_N-1:0] ev_q, set_v;

  always_comb begin
    set_v         = '0;
    set_v[EV_CRC]  = crc_set;
    set_v[EV_FLAG] = flag_set;
    set_v[EV_CTS]  = cts_vld && (cts != cts_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cts_q   <= 1'b0;
      cts_vld <= 1'b0;
      ev_q    <= '0;
      ovr_q   <= 1'b0;
    end else begin
      cts_q   <= cts;
      cts_vld <= 1'b1;
      if (clr) begin
        ev_q  <= '0;
        ovr_q <= 1'b0;
      end else begin
        for (int i = 0; i < EV_N; i++)
          ev_q[i] <= (ev_q[i] && !ack) || set_v[i];
        ovr_q <= (ovr_q && !ack) || ovr_set;
      end
    end
  end

  assign ev      = ev_q;
  assign overrun = ovr_q;
  assign irq     = ie && (|ev_q);
endmodule

// File: rtl/ftx_sdlc_tx.sv
module ftx_sdlc_tx
  import ftx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int MIN_BITS = 5,
  parameter int LEN_W = 2,
  parameter int CRC_W = 16,
  parameter logic [CRC_W-1:0] CRC_POLY = 16'h8408,
  parameter logic [CRC_W-1:0] CRC_INIT = 16'hFFFF,
  parameter int FLAG_W = 8,
  parameter logic [FLAG_W-1:0] FLAG_PAT = 8'h7E,
  parameter int RUN_MAX = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_reset,
  input  logic              bit_en,
  input  logic [LEN_W-1:0]  char_len,
  input  logic              auto_en,
  input  logic              cts,
  input  logic              stat_ie,
  input  logic              stat_ack,
  input  logic              buf_wr,
  input  logic [DATA_W-1:0] buf_data,
  output logic              buf_empty,
  output logic              overrun,
  output logic              txd,
  output logic              ev_crc,
  output logic              ev_flag,
  output logic              ev_cts,
  output logic              stat_irq
);
  localparam int CNT_W = $clog2(CRC_W);
  localparam int RUN_W = $clog2(RUN_MAX + 2);
  localparam logic [CNT_W-1:0] FLAG_CNT = CNT_W'(FLAG_W - 1);
  localparam logic [CNT_W-1:0] FCS_CNT  = CNT_W'(CRC_W - 1);
  localparam logic [CRC_W-1:0] FLAG_WORD = {{(CRC_W-FLAG_W){1'b0}}, FLAG_PAT};

  ftx_mode_e        mode_q;
  logic [CRC_W-1:0] sh_q, crc_q, crc_nxt, load_word;
  logic [CNT_W-1:0] cnt_q, load_cnt;
  logic [RUN_W-1:0] run_q;
  logic             txd_q;
  logic             buf_full, buf_reject, take;
  logic [DATA_W-1:0] buf_q;
  logic             stuff_now, cur_bit, at_end, start_ok;
  logic             crc_evt, flag_evt;
  logic [EV_N-1:0]  ev;

  assign stuff_now = (run_q == RUN_W'(RUN_MAX));
  assign cur_bit   = sh_q[0];
  assign at_end    = bit_en && !stuff_now && (cnt_q == '0) && !chan_reset;
  assign start_ok  = !auto_en || cts;
  assign take      = at_end && buf_full &&
                     ((mode_q == M_DATA) || ((mode_q == M_FLAG) && start_ok));
  assign crc_evt   = at_end && (mode_q == M_DATA) && !buf_full;
  assign flag_evt  = at_end && (mode_q == M_FCS);
  assign load_word = {{(CRC_W-DATA_W){1'b0}}, buf_q};
  assign load_cnt  = CNT_W'(char_len) + CNT_W'(MIN_BITS - 1);

  ftx_txbuf #(.DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(chan_reset), .wr(buf_wr), .wdata(buf_data),
    .take(take), .full(buf_full), .q(buf_q), .reject(buf_reject)
  );

  ftx_crc #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
    .crc_i(crc_q), .bit_i(cur_bit), .crc_o(crc_nxt)
  );

  ftx_status u_stat (
    .clk(clk), .rst_n(rst_n), .clr(chan_reset), .ack(stat_ack), .ie(stat_ie),
    .cts(cts), .crc_set(crc_evt), .flag_set(flag_evt), .ovr_set(buf_reject),
    .ev(ev), .overrun(overrun), .irq(stat_irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_FLAG;
      sh_q   <= FLAG_WORD;
      cnt_q  <= FLAG_CNT;
      run_q  <= '0;
      crc_q  <= CRC_INIT;
      txd_q  <= 1'b1;
    end else if (chan_reset) begin
      mode_q <= M_FLAG;
      sh_q   <= FLAG_WORD;
      cnt_q  <= FLAG_CNT;
      run_q  <= '0;
      crc_q  <= CRC_INIT;
      txd_q  <= 1'b1;
    end else if (bit_en) begin
      if (stuff_now) begin
        txd_q <= 1'b0;
        run_q <= '0;
      end else begin
        txd_q <= cur_bit;
        sh_q  <= sh_q >> 1;
        cnt_q <= cnt_q - CNT_W'(1);
        if (mode_q == M_FLAG)  run_q <= '0;
        else if (cur_bit)      run_q <= run_q + RUN_W'(1);
        else                   run_q <= '0;
        if (mode_q == M_DATA) crc_q <= crc_nxt;
        if (cnt_q == '0) begin
          case (mode_q)
            M_FLAG: begin
              if (take) begin
                sh_q   <= load_word;
                cnt_q  <= load_cnt;
                mode_q <= M_DATA;
                crc_q  <= CRC_INIT;
              end else begin
                sh_q  <= FLAG_WORD;
                cnt_q <= FLAG_CNT;
              end
            end
            M_DATA: begin
              if (take) begin
                sh_q  <= load_word;
                cnt_q <= load_cnt;
              end else begin
                sh_q   <= ~crc_nxt;
                cnt_q  <= FCS_CNT;
                mode_q <= M_FCS;
              end
            end
            default: begin
              sh_q   <= FLAG_WORD;
              cnt_q  <= FLAG_CNT;
              mode_q <= M_FLAG;
            end
          endcase
        end
      end
    end
  end

  assign txd       = txd_q;
  assign buf_empty = !buf_full;
  assign ev_crc    = ev[EV_CRC];
  assign ev_flag   = ev[EV_FLAG];
  assign ev_cts    = ev[EV_CTS];
endmodule

// File: rtl/ftx_sdlc_tx_chk.sv
module ftx_sdlc_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic chan_reset,
  input logic bit_en,
  input logic buf_wr,
  input logic buf_empty,
  input logic overrun,
  input logic txd,
  input logic ev_crc,
  input logic ev_flag,
  input logic ev_cts
);
  logic       be_q;
  logic [2:0] ones_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      be_q   <= 1'b0;
      ones_q <= '0;
    end else begin
      be_q <= bit_en && !chan_reset;
      if (chan_reset)  ones_q <= '0;
      else if (be_q)   ones_q <= txd ? ((ones_q == 3'd7) ? 3'd7 : ones_q + 3'd1) : 3'd0;
    end
  end

  // R4: stuffing keeps the line below seven ones in a row
  p_no_seven_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ones_q <= 3'd6);

  // R9: accepted write fills the holding register
  p_write_fills_r9: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr && buf_empty && !chan_reset |=> !buf_empty);

  // R9: write to a full register raises overrun
  p_overrun_r9: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr && !buf_empty && !chan_reset |=> overrun);

  // R10: channel reset clears everything
  p_chan_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    chan_reset |=> buf_empty && !overrun && !ev_crc && !ev_flag && !ev_cts && txd);

  // R11: line holds without a bit enable
  p_line_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en && !chan_reset |=> $stable(txd));
endmodule

bind ftx_sdlc_tx ftx_sdlc_tx_chk u_chk (.*);

// File: tb/sim_ftx_sdlc_tx.sv
`timescale 1ns/1ps
module sim_ftx_sdlc_tx;
  localparam int MAXB = 2048;

  logic clk = 0, rst_n = 0, chan_reset = 0, auto_en = 0, cts = 0;
  logic stat_ie = 0, stat_ack = 0, buf_wr = 0;
  logic [1:0] char_len = 2'd3;
  logic [7:0] buf_data = 8'd0;
  logic be_hold = 0, throttle = 0, tog = 0;
  logic bit_en;
  logic buf_empty, overrun, txd, ev_crc, ev_flag, ev_cts, stat_irq;

  assign bit_en = !be_hold && (!throttle || tog);
  always #2 clk = ~clk;

  ftx_sdlc_tx u0 (
    .clk(clk), .rst_n(rst_n), .chan_reset(chan_reset), .bit_en(bit_en),
    .char_len(char_len), .auto_en(auto_en), .cts(cts), .stat_ie(stat_ie),
    .stat_ack(stat_ack), .buf_wr(buf_wr), .buf_data(buf_data),
    .buf_empty(buf_empty), .overrun(overrun), .txd(txd), .ev_crc(ev_crc),
    .ev_flag(ev_flag), .ev_cts(ev_cts), .stat_irq(stat_irq)
  );

  int checks = 0, errors = 0, cycles = 0;
  bit bits[MAXB]; int n_bits = 0; bit cap_on = 0; bit be_q = 0;
  bit fr[MAXB]; int fr_len, nframes, nflags, fr_stuffs;
  bit exp_b[MAXB]; int exp_len = 0;

  always @(posedge clk) be_q <= bit_en && !chan_reset && rst_n;
  always @(negedge clk) begin
    tog <= ~tog;
    if (be_q && cap_on && n_bits < MAXB) begin bits[n_bits] = txd; n_bits++; end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      errors++;
      $display("FAIL watchdog R1..: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic ack();
    @(negedge clk); stat_ack = 1;
    @(negedge clk); stat_ack = 0;
  endtask

  task automatic write(input logic [7:0] d, input logic [1:0] code);
    @(negedge clk); buf_wr = 1; buf_data = d; char_len = code;
    @(negedge clk); buf_wr = 0;
  endtask

  task automatic wait_empty(input string tag);
    int t = 0;
    while (!buf_empty && t < 4000) begin @(negedge clk); t++; end
    if (t >= 4000) chk({tag, " empty timeout"}, 0, 1);
  endtask

  task automatic add_char(input logic [7:0] d, input logic [1:0] code);
    for (int i = 0; i < int'(code) + 5; i++) begin exp_b[exp_len] = d[i]; exp_len++; end
  endtask

  task automatic send(input logic [7:0] d, input logic [1:0] code);
    wait_empty("send");
    write(d, code);
    add_char(d, code);
  endtask

  task automatic begin_cap();
    ack();
    n_bits = 0; exp_len = 0; cap_on = 1;
    repeat (40) @(negedge clk);
  endtask

  task automatic decode();
    int ones = 0, coll = 0, stf = 0;
    bit seen = 0;
    bit acc[MAXB];
    nframes = 0; nflags = 0; fr_len = 0; fr_stuffs = 0;
    for (int i = 0; i < n_bits; i++) begin
      if (bits[i]) begin acc[coll] = 1; coll++; ones++; end
      else if (ones == 5) begin ones = 0; stf++; end
      else if (ones == 6) begin
        nflags++;
        if (seen && coll > 7) begin
          if (nframes == 0) begin
            fr_len = coll - 7; fr_stuffs = stf;
            for (int j = 0; j < fr_len; j++) fr[j] = acc[j];
          end
          nframes++;
        end
        seen = 1; coll = 0; ones = 0; stf = 0;
      end else begin acc[coll] = 0; coll++; ones = 0; end
    end
  endtask

  task automatic check_frame(input string tag);
    logic [15:0] crc, fcs_exp, fcs_got;
    int bad = 0, run = 0, stf = 0;
    bit b;
    decode();
    crc = 16'hFFFF;
    for (int i = 0; i < exp_len; i++) begin
      b = exp_b[i];
      if (crc[0] ^ b) crc = (crc >> 1) ^ 16'h8408; else crc = crc >> 1;
    end
    fcs_exp = ~crc;
    for (int i = 0; i < exp_len + 16; i++) begin
      b = (i < exp_len) ? exp_b[i] : fcs_exp[i - exp_len];
      if (b) begin run++; if (run == 5) begin stf++; run = 0; end end
      else run = 0;
    end
    for (int i = 0; i < exp_len; i++) if (fr[i] != exp_b[i]) bad++;
    for (int i = 0; i < 16; i++) fcs_got[i] = fr[exp_len + i];
    chk({tag, " R5 closed frame count"}, nframes, 1);
    chk({tag, " R2 frame length"}, fr_len, exp_len + 16);
    chk({tag, " R2 data bit mismatches"}, bad, 0);
    chk({tag, " R5 check sequence"}, int'(fcs_got), int'(fcs_exp));
    chk({tag, " R4 stuffed zeros"}, fr_stuffs, stf);
  endtask

  task automatic finish_frame(input string tag);
    int t = 0;
    bit crc_first = 0;
    while (!ev_flag && t < 4000) begin
      @(negedge clk);
      if (ev_crc && !ev_flag) crc_first = 1;
      t++;
    end
    chk({tag, " R7 ev_crc before ev_flag"}, int'(crc_first), 1);
    repeat (40) @(negedge clk);
    cap_on = 0;
    check_frame(tag);
  endtask

  task automatic t_reset();
    chk("R1 buf_empty", int'(buf_empty), 1);
    chk("R1 overrun", int'(overrun), 0);
    chk("R1 events", int'({ev_crc, ev_flag, ev_cts}), 0);
    chk("R1 stat_irq", int'(stat_irq), 0);
    n_bits = 0; cap_on = 1;
    repeat (64) @(negedge clk);
    cap_on = 0;
    decode();
    chk("R1 idle frames", nframes, 0);
    chk("R1 R4 unstuffed flags seen", int'(nflags >= 6), 1);
  endtask

  task automatic t_lengths();
    stat_ie = 1;
    begin_cap();
    send(8'hE3, 2'd0); send(8'hC5, 2'd1); send(8'h9A, 2'd2); send(8'h3C, 2'd3);
    finish_frame("R2 mixed lengths");
    chk("R8 irq with enable", int'(stat_irq), 1);
  endtask

  task automatic t_stuffing();
    stat_ie = 0;
    begin_cap();
    send(8'hFF, 2'd3); send(8'hFF, 2'd3); send(8'h7E, 2'd3); send(8'h1F, 2'd0);
    finish_frame("R4 ones");
    chk("R8 events latched while disabled", int'({ev_crc, ev_flag}), 3);
    chk("R8 irq masked", int'(stat_irq), 0);
  endtask

  task automatic t_len_change();
    begin_cap();
    send(8'hA5, 2'd3);
    send(8'hF3, 2'd0);
    send(8'h6B, 2'd3);
    finish_frame("R3 length change");
    ack();
    chk("R7 ack clears events", int'({ev_crc, ev_flag, ev_cts}), 0);
  endtask

  task automatic t_throttle();
    logic t0;
    throttle = 1;
    begin_cap();
    send(8'h81, 2'd3); send(8'h5E, 2'd2);
    finish_frame("R11 half rate");
    throttle = 0;
    @(negedge clk);
    be_hold = 1;
    @(negedge clk);
    t0 = txd;
    begin
      int moved = 0;
      repeat (20) begin @(negedge clk); if (txd !== t0) moved++; end
      chk("R11 txd held", moved, 0);
    end
    be_hold = 0;
  endtask

  task automatic t_auto();
    auto_en = 1; cts = 0;
    begin_cap();
    write(8'hD2, 2'd3); add_char(8'hD2, 2'd3);
    repeat (80) @(negedge clk);
    chk("R6 held while cts low", int'(buf_empty), 0);
    cts = 1;
    @(negedge clk);
    chk("R7 ev_cts on change", int'(ev_cts), 1);
    finish_frame("R6 gated start");
    auto_en = 0; cts = 0;
  endtask

  task automatic t_overrun();
    auto_en = 1; cts = 0;
    begin_cap();
    write(8'h5A, 2'd3);
    chk("R9 write clears empty", int'(buf_empty), 0);
    chk("R9 no overrun yet", int'(overrun), 0);
    write(8'hC3, 2'd3);
    chk("R9 overrun flagged", int'(overrun), 1);
    ack();
    chk("R9 overrun cleared by ack", int'(overrun), 0);
    add_char(8'h5A, 2'd3);
    cts = 1;
    finish_frame("R9 dropped write");
    auto_en = 0; cts = 0;
  endtask

  task automatic t_chan_reset();
    auto_en = 1; cts = 0;
    ack();
    write(8'h77, 2'd3);
    write(8'h88, 2'd3);
    chk("R10 pre overrun", int'(overrun), 1);
    @(negedge clk); chan_reset = 1;
    @(negedge clk); chan_reset = 0;
    chk("R10 buf_empty", int'(buf_empty), 1);
    chk("R10 overrun", int'(overrun), 0);
    chk("R10 events", int'({ev_crc, ev_flag, ev_cts}), 0);
    chk("R10 txd idle high", int'(txd), 1);
    cts = 1;
    begin_cap();
    repeat (40) @(negedge clk);
    cap_on = 0;
    decode();
    chk("R10 no frame after reset", nframes, 0);
    chk("R10 flags resume", int'(nflags >= 6), 1);
    auto_en = 0; cts = 0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_lengths();
    t_stuffing();
    t_len_change();
    t_throttle();
    t_auto();
    t_overrun();
    t_chan_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule